// File: doc/BRIEF.md
# Configuration byte programming sequencer

This block drives a serial command shifter to program two neighbouring bytes of a device's configuration space. After one start strobe it walks a fixed list of steps. Each step hands the shifter a 4-bit command and a 16-bit payload. The list does five things in order: it switches the target into configuration-space access, moves the program counter away from the protected region, loads a 22-bit table pointer one byte at a time (upper, high, low), programs the bytes, and raises a done flag.

Configuration cells are written one byte per write command, although each payload is 16 bits wide. The address parity selects the byte lane that carries the data: an even address uses the low lane and an odd address uses the high lane. The lane that carries no data is sent as zero. For an even start address, the even byte is written first, then an operand increments the pointer's low byte, and then the odd byte is written. For an odd start address, only the odd byte is written. Every write is followed by a programming hold of `HOLD_CYCLES` clock cycles. The block issues no request during that hold.

The sequencer issues one step at a time. It raises a single-cycle request, keeps the command and payload steady, and waits for the shifter's done pulse before it moves on.

States: `ST_IDLE` (waits for start), `ST_LAUNCH` (request pulse), `ST_WAIT` (waits for shifter done), `ST_HOLD` (programming hold after a write), `ST_FINISH` (done pulse). The transitions are:
- IDLE→LAUNCH on start.
- LAUNCH→WAIT always.
- WAIT→LAUNCH on done for an ordinary operand.
- WAIT→HOLD on done for a write.
- HOLD→LAUNCH when the hold expires and steps remain.
- HOLD→FINISH when the hold after the last write expires.
- FINISH→IDLE always.

Top module: `cfg_byte_prog_seq`

## Requirements
- R1: After reset, `sh_req_o` and `done_o` are low and the block is idle.
- R2: The first four steps carry command 4'b0000 with payloads 16'h8EA6, 16'h8CA6, 16'hEF00 and 16'hF800, in that order.
- R3: The next six steps (command 4'b0000) load the pointer. The payloads are {8'h0E, upper}, 16'h6EF8, {8'h0E, addr[15:8]}, 16'h6EF7, {8'h0E, addr[7:0]}, 16'h6EF6, where upper is addr[21:16] zero-extended to 8 bits.
- R4: For an even address, the pointer load is followed by three steps: a write (command 4'b1111) with payload {8'h00, even byte}, then command 4'b0000 with payload 16'h2AF6, then a write with payload {odd byte, 8'h00}. That makes 13 steps.
- R5: For an odd address, the pointer load is followed directly by one write with payload {odd byte, 8'h00}. The increment and the even write are skipped, which makes 11 steps.
- R6: `sh_req_o` is a one-cycle pulse, and no new request is raised before `sh_done_i`. After the done pulse of a non-write step, the next request comes in the next cycle.
- R7: After the done pulse of a write, exactly `HOLD_CYCLES` cycles pass with no request before the next request. After the last write, the same number of cycles pass before `done_o`.
- R8: `done_o` is a single-cycle pulse. A start strobe seen while a sequence is running has no effect on the steps issued.
- R9: `sh_cmd_o` and `sh_payload_o` stay constant from a request until the matching `sh_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; sampled only when idle |
| base_addr_i | input | 22 | Address of the first byte to program |
| even_byte_i | input | 8 | Data byte for the even address |
| odd_byte_i | input | 8 | Data byte for the odd address |
| sh_req_o | output | 1 | One-cycle step request to the shifter |
| sh_cmd_o | output | 4 | 4-bit command of the current step |
| sh_payload_o | output | 16 | 16-bit payload of the current step |
| sh_done_i | input | 1 | Shifter finished the current step |
| done_o | output | 1 | One-cycle pulse when the sequence ends |

## Verification
Each fault in the step counter or the parity branch shows up at the shifter port when the affected step is issued. A wrong payload, an extra step or a missing step appears at the first wrong request, which is at most one handshake after the fault. A fault in the hold timer or the FSM changes the spacing between a done pulse and the next request. It shows up within `HOLD_CYCLES` + 1 cycles of a write, or as a `done_o` at the wrong time. A start strobe that leaks in while the block is busy restarts or rewrites the step list, and the next payload comparison reports it.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT,
        ST_HOLD,
        ST_FINISH
    } seq_state_e;

    localparam int STEP_W = 4;

    localparam logic [STEP_W-1:0] STEP_FIRST    = 4'd0;
    localparam logic [STEP_W-1:0] STEP_PTR_DONE = 4'd9;
    localparam logic [STEP_W-1:0] STEP_EVEN_WR  = 4'd10;
    localparam logic [STEP_W-1:0] STEP_BUMP     = 4'd11;
    localparam logic [STEP_W-1:0] STEP_ODD_WR   = 4'd12;

    localparam logic [3:0] CMD_CORE  = 4'b0000;
    localparam logic [3:0] CMD_WRITE = 4'b1111;

    localparam logic [15:0] OPR_SPACE_A  = 16'h8EA6;
    localparam logic [15:0] OPR_SPACE_B  = 16'h8CA6;
    localparam logic [15:0] OPR_JUMP_A   = 16'hEF00;
    localparam logic [15:0] OPR_JUMP_B   = 16'hF800;
    localparam logic [7:0]  OPR_LIT_HI   = 8'h0E;
    localparam logic [15:0] OPR_ST_UPPER = 16'h6EF8;
    localparam logic [15:0] OPR_ST_HIGH  = 16'h6EF7;
    localparam logic [15:0] OPR_ST_LOW   = 16'h6EF6;
    localparam logic [15:0] OPR_INC_LOW  = 16'h2AF6;

    // Step that follows cur; odd start addresses jump past the even write.
    function automatic logic [STEP_W-1:0] next_step(input logic [STEP_W-1:0] cur,
                                                    input logic odd_start);
        if (cur == STEP_PTR_DONE)
            return odd_start ? STEP_ODD_WR : STEP_EVEN_WR;
        return cur + 1'b1;
    endfunction

endpackage

// File: rtl/cfgseq_step_rom.sv
module cfgseq_step_rom
    import cfgseq_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        even_i,
    input  logic [7:0]        odd_i,
    output logic [3:0]        cmd_o,
    output logic [15:0]       payload_o,
    output logic              is_write_o
);
    localparam int UP_W = ADDR_W - 16;

    logic [7:0] upper_b;
    assign upper_b = {{(8 - UP_W){1'b0}}, addr_i[ADDR_W-1:16]};

    always_comb begin
        cmd_o      = CMD_CORE;
        payload_o  = 16'h0000;
        is_write_o = 1'b0;
        unique case (step_i)
            4'd0:  payload_o = OPR_SPACE_A;
            4'd1:  payload_o = OPR_SPACE_B;
            4'd2:  payload_o = OPR_JUMP_A;
            4'd3:  payload_o = OPR_JUMP_B;
            4'd4:  payload_o = {OPR_LIT_HI, upper_b};
            4'd5:  payload_o = OPR_ST_UPPER;
            4'd6:  payload_o = {OPR_LIT_HI, addr_i[15:8]};
            4'd7:  payload_o = OPR_ST_HIGH;
            4'd8:  payload_o = {OPR_LIT_HI, addr_i[7:0]};
            4'd9:  payload_o = OPR_ST_LOW;
            4'd10: begin
                cmd_o      = CMD_WRITE;
                payload_o  = {8'h00, even_i};
                is_write_o = 1'b1;
            end
            4'd11: payload_o = OPR_INC_LOW;
            4'd12: begin
                cmd_o      = CMD_WRITE;
                payload_o  = {odd_i, 8'h00};
                is_write_o = 1'b1;
            end
            default: payload_o = 16'h0000;
        endcase
    end
endmodule

// File: rtl/cfgseq_hold_timer.sv
module cfgseq_hold_timer #(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= CNT_W'(HOLD_CYCLES - 1);
        else if (run_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    a_r7_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == CNT_W'(HOLD_CYCLES - 1)));
endmodule

// File: rtl/cfg_byte_prog_seq.sv
module cfg_byte_prog_seq
    import cfgseq_pkg::*;
#(
    parameter int ADDR_W      = 22,
    parameter int HOLD_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [7:0]        even_byte_i,
    input  logic [7:0]        odd_byte_i,
    output logic              sh_req_o,
    output logic [3:0]        sh_cmd_o,
    output logic [15:0]       sh_payload_o,
    input  logic              sh_done_i,
    output logic              done_o
);
    seq_state_e        state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        even_q, odd_q;
    logic              is_write;
    logic              hold_load, hold_expired;

    cfgseq_step_rom #(.ADDR_W(ADDR_W)) rom_i (
        .step_i     (step_q),
        .addr_i     (addr_q),
        .even_i     (even_q),
        .odd_i      (odd_q),
        .cmd_o      (sh_cmd_o),
        .payload_o  (sh_payload_o),
        .is_write_o (is_write)
    );

    cfgseq_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (hold_load),
        .run_i     (state_q == ST_HOLD),
        .expired_o (hold_expired)
    );

    // Next-state and step selection
    always_comb begin
        state_d   = state_q;
        step_d    = step_q;
        hold_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_LAUNCH;
                    step_d  = STEP_FIRST;
                end
            end
            ST_LAUNCH: state_d = ST_WAIT;
            ST_WAIT: begin
                if (sh_done_i) begin
                    if (is_write) begin
                        state_d   = ST_HOLD;
                        hold_load = 1'b1;
                    end else begin
                        state_d = ST_LAUNCH;
                        step_d  = next_step(step_q, addr_q[0]);
                    end
                end
            end
            ST_HOLD: begin
                if (hold_expired) begin
                    if (step_q == STEP_ODD_WR) begin
                        state_d = ST_FINISH;
                    end else begin
                        state_d = ST_LAUNCH;
                        step_d  = next_step(step_q, addr_q[0]);
                    end
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State, step and captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= STEP_FIRST;
            addr_q  <= '0;
            even_q  <= '0;
            odd_q   <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            if (state_q == ST_IDLE && start_i) begin
                addr_q <= base_addr_i;
                even_q <= even_byte_i;
                odd_q  <= odd_byte_i;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        sh_req_o = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_LAUNCH: sh_req_o = 1'b1;
            ST_FINISH: done_o   = 1'b1;
            default: ;
        endcase
    end

    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!sh_req_o && !done_o));

    a_r6_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sh_req_o |=> !sh_req_o);

    a_r5_odd_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_req_o && addr_q[0]) |-> (step_q != STEP_EVEN_WR && step_q != STEP_BUMP));

    a_r7_hold_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && hold_expired) |=> (sh_req_o || done_o));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> ($stable(sh_cmd_o) && $stable(sh_payload_o)));
endmodule

// File: tb/cfg_byte_prog_seq_tb_top.sv
module cfg_byte_prog_seq_tb_top;
    localparam int HOLD = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [21:0] base_addr_i = '0;
    logic [7:0]  even_byte_i = '0;
    logic [7:0]  odd_byte_i = '0;
    logic        sh_req_o;
    logic [3:0]  sh_cmd_o;
    logic [15:0] sh_payload_o;
    logic        sh_done_i = 1'b0;
    logic        done_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [3:0]  exp_cmd [0:12];
    logic [15:0] exp_pay [0:12];
    bit          exp_wr  [0:12];
    string       exp_tag [0:12];
    int          exp_n;

    always #2 clk = ~clk;

    cfg_byte_prog_seq #(.ADDR_W(22), .HOLD_CYCLES(HOLD)) dut_i (
        .clk, .rst_n, .start_i, .base_addr_i, .even_byte_i, .odd_byte_i,
        .sh_req_o, .sh_cmd_o, .sh_payload_o, .sh_done_i, .done_o
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic add(input logic [3:0] c, input logic [15:0] p, input bit w, input string t);
        exp_cmd[exp_n] = c;
        exp_pay[exp_n] = p;
        exp_wr[exp_n]  = w;
        exp_tag[exp_n] = t;
        exp_n++;
    endtask

    task automatic build(input logic [21:0] a, input logic [7:0] ev, input logic [7:0] od);
        exp_n = 0;
        add(4'b0000, 16'h8EA6, 0, "R2");
        add(4'b0000, 16'h8CA6, 0, "R2");
        add(4'b0000, 16'hEF00, 0, "R2");
        add(4'b0000, 16'hF800, 0, "R2");
        add(4'b0000, {8'h0E, 2'b00, a[21:16]}, 0, "R3");
        add(4'b0000, 16'h6EF8, 0, "R3");
        add(4'b0000, {8'h0E, a[15:8]}, 0, "R3");
        add(4'b0000, 16'h6EF7, 0, "R3");
        add(4'b0000, {8'h0E, a[7:0]}, 0, "R3");
        add(4'b0000, 16'h6EF6, 0, "R3");
        if (!a[0]) begin
            add(4'b1111, {8'h00, ev}, 1, "R4");
            add(4'b0000, 16'h2AF6, 0, "R4");
            add(4'b1111, {od, 8'h00}, 1, "R4");
        end else begin
            add(4'b1111, {od, 8'h00}, 1, "R5");
        end
    endtask

    // One full sequence; spam=1 holds start high while busy (R8)
    task automatic run_case(input logic [21:0] a, input logic [7:0] ev,
                            input logic [7:0] od, input int lat, input bit spam);
        int waited;
        logic [15:0] cap_pay;
        logic [3:0]  cap_cmd;
        build(a, ev, od);
        @(negedge clk);
        base_addr_i = a; even_byte_i = ev; odd_byte_i = od; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < exp_n; i++) begin
            waited = 0;
            while (!sh_req_o && waited < 50) begin
                @(negedge clk);
                waited++;
            end
            if (i == 0)
                chk(waited == 0, "R6", "first request delay", waited, 0);
            else if (exp_wr[i-1])
                chk(waited == HOLD, "R7", "hold before request", waited, HOLD);
            else
                chk(waited == 0, "R6", "gap after operand", waited, 0);
            chk(sh_cmd_o == exp_cmd[i], spam ? "R8" : exp_tag[i], "command",
                sh_cmd_o, exp_cmd[i]);
            chk(sh_payload_o == exp_pay[i], spam ? "R8" : exp_tag[i], "payload",
                sh_payload_o, exp_pay[i]);
            cap_cmd = sh_cmd_o;
            cap_pay = sh_payload_o;
            if (spam) begin
                base_addr_i = ~a; even_byte_i = ~ev; odd_byte_i = ~od; start_i = 1'b1;
            end
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                chk(!sh_req_o, "R6", "request while waiting", sh_req_o, 0);
            end
            chk(sh_payload_o == cap_pay && sh_cmd_o == cap_cmd, "R9", "held payload",
                sh_payload_o, cap_pay);
            sh_done_i = 1'b1;
            @(negedge clk);
            sh_done_i = 1'b0;
            start_i = 1'b0;
        end
        waited = 0;
        while (!done_o && waited < 50) begin
            if (sh_req_o)
                chk(0, exp_wr[exp_n-1] ? "R5" : "R4", "extra request", 1, 0);
            @(negedge clk);
            waited++;
        end
        chk(waited == HOLD, "R7", "hold before done", waited, HOLD);
        @(negedge clk);
        chk(!done_o, "R8", "done width", done_o, 0);
        chk(!sh_req_o, "R8", "request after done", sh_req_o, 0);
    endtask

    task automatic test_reset;
        chk(!sh_req_o, "R1", "request in reset", sh_req_o, 0);
        chk(!done_o, "R1", "done in reset", done_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!sh_req_o && !done_o, "R1", "idle after reset", {sh_req_o, done_o}, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        run_case(22'h300000, 8'hA5, 8'h3C, 1, 0);   // even path R4
        run_case(22'h300005, 8'h11, 8'h7E, 2, 0);   // odd path R5
        run_case(22'h3000FE, 8'hFF, 8'h00, 3, 1);   // start while busy R8
        run_case(22'h12F3B7, 8'h5A, 8'hC3, 1, 0);   // other upper byte R3
        run_case(22'h0ABC42, 8'h81, 8'h18, 2, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule